// File: doc/BRIEF.md
# Poisoned-Data Parity Forwarding Unit

This block moves data-corruption information in both directions across a bridge between a packet link and a 32-bit parallel bus. Going down, it takes payload double-words of packets headed for the parallel bus and drives them as data phases. Each phase gets even parity. If the packet is flagged as poisoned, the block inverts that parity on every phase, so the bus target sees a parity error on all of the packet's data.

Going up, the block watches write data phases on the parallel bus for which the bridge is the target. It checks each phase against the parity that arrives one clock later and passes the data on unchanged. At the end of the transaction it issues a header word. The header carries a poison flag and the phase count, and the flag is set if any phase failed its check. The header is issued only once the last phase has been checked, so the flag is already final when the packet assembler reads it.

Top module: `epf_top`

## Requirements
- R1: After reset, `bus_phase_o`, `bus_par_en_o`, `up_dv_o` and `up_hdr_valid_o` are all 0.
- R2: A downstream dword accepted on a clock edge with `dn_valid` high appears on `bus_dat_o`/`bus_ben_o` after that edge, with `bus_phase_o` high, for exactly one cycle per dword. Back-to-back dwords give back-to-back phases.
- R3: Parity for a data phase appears on `bus_parity_o`, with `bus_par_en_o` high, in the cycle that follows the phase. For a packet that is not poisoned, the parity is even: the total count of ones in `bus_dat_o`, `bus_ben_o` and the parity bit is even.
- R4: For a poisoned packet, the parity of every data phase is the inverse of the even parity.
- R5: The poison flag is sampled with the first dword of a packet, which is the first valid dword after reset or after a dword with `dn_last` high. Changes on `dn_poison` during the packet's later dwords have no effect. The next packet samples the flag afresh.
- R6: Each upstream data phase is forwarded unchanged on `up_data_o` with `up_dv_o` high, two cycles after the phase. `up_derr_o` shows whether that phase failed its parity check.
- R7: The header poison flag `up_hdr_poison_o` is 1 if and only if at least one phase of the transaction failed its check, whether that phase is the first, a middle one or the last.
- R8: `up_hdr_valid_o` is high for one cycle, in the same cycle as the forwarded last data phase and never earlier. `up_hdr_len_o` then equals the number of data phases in the transaction.
- R9: Parity errors in one upstream transaction do not affect the header of the following transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dn_valid | input | 1 | Downstream dword present this cycle |
| dn_data | input | DW | Downstream payload dword |
| dn_ben | input | BW | Byte-enable code driven with the dword |
| dn_last | input | 1 | Last dword of the packet |
| dn_poison | input | 1 | Packet poisoned flag, sampled on the first dword |
| bus_phase_o | output | 1 | Downstream data phase on the bus |
| bus_dat_o | output | DW | Bus data for the phase |
| bus_ben_o | output | BW | Bus byte-enable code for the phase |
| bus_par_en_o | output | 1 | Parity for the previous phase is valid |
| bus_parity_o | output | 1 | Parity bit, one cycle after its phase |
| bus_phase_i | input | 1 | Upstream write data phase on the bus |
| bus_dat_i | input | DW | Upstream bus data |
| bus_ben_i | input | BW | Upstream bus byte-enable code |
| bus_last_i | input | 1 | Last data phase of the upstream transaction |
| bus_parity_i | input | 1 | Parity for the phase of the previous cycle |
| up_dv_o | output | 1 | Checked upstream dword valid |
| up_data_o | output | DW | Checked upstream dword |
| up_derr_o | output | 1 | That dword failed its parity check |
| up_hdr_valid_o | output | 1 | Upstream header word valid |
| up_hdr_poison_o | output | 1 | Header poison flag |
| up_hdr_len_o | output | LW | Number of data phases in the transaction |

## Verification
The bench uses the default parameters: a 32-bit data path, a 4-bit byte-enable code and an 8-bit length field. Transactions of one to eight phases therefore stay well clear of wrap-around in the length field. With these widths, every phase of a packet can be compared against a parity the bench computes itself. Error masks are placed on the first, a middle and the last phase of an upstream transaction, and the poison input is toggled partway through a downstream packet. A clean packet is sent right after a poisoned one, so leftover state from the previous packet would show up as a wrong parity or header flag.

// File: rtl/epf_pkg.sv
package epf_pkg;
  // Even parity bit over a zero-extended vector: xor of all bits.
  function automatic logic epf_even(input logic [63:0] vec);
    return ^vec;
  endfunction
endpackage

// File: rtl/epf_dn_gen.sv
module epf_dn_gen #(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [BW-1:0] in_ben,
  input  logic          in_last,
  input  logic          in_poison,
  output logic          ph_o,
  output logic [DW-1:0] dat_o,
  output logic [BW-1:0] ben_o,
  output logic          par_en_o,
  output logic          par_o
);
  import epf_pkg::*;

  logic          ph_q, paren_q, par_q, pois_q, inpkt_q, lat_q;
  logic [DW-1:0] dat_q;
  logic [BW-1:0] ben_q;
  logic          inpkt_d, lat_d, pois_eff, par_d;

  always_comb begin
    pois_eff = inpkt_q ? lat_q : in_poison;
    inpkt_d  = in_valid ? !in_last : inpkt_q;
    lat_d    = (in_valid && !inpkt_q) ? in_poison : lat_q;
    par_d    = epf_even(64'({dat_q, ben_q})) ^ pois_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= 1'b0;
      paren_q <= 1'b0;
      par_q   <= 1'b0;
      pois_q  <= 1'b0;
      inpkt_q <= 1'b0;
      lat_q   <= 1'b0;
      dat_q   <= '0;
      ben_q   <= '0;
    end else begin
      ph_q    <= in_valid;
      paren_q <= ph_q;
      inpkt_q <= inpkt_d;
      lat_q   <= lat_d;
      if (in_valid) begin
        dat_q  <= in_data;
        ben_q  <= in_ben;
        pois_q <= pois_eff;
      end
      if (ph_q) par_q <= par_d;
    end
  end

  assign ph_o     = ph_q;
  assign dat_o    = dat_q;
  assign ben_o    = ben_q;
  assign par_en_o = paren_q;
  assign par_o    = par_q;

  a_r3_par_after_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q |=> paren_q);
  a_r5_flag_held_in_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inpkt_q) |=> $stable(lat_q));
endmodule

// File: rtl/epf_up_chk.sv
module epf_up_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 4,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph_i,
  input  logic [DW-1:0] dat_i,
  input  logic [BW-1:0] ben_i,
  input  logic          last_i,
  input  logic          par_i,
  output logic          dv_o,
  output logic [DW-1:0] data_o,
  output logic          derr_o,
  output logic          hv_o,
  output logic          hp_o,
  output logic [LW-1:0] hl_o
);
  import epf_pkg::*;

  logic          ph_q, last_q, acc_q, dv_q, derr_q, hv_q, hp_q;
  logic [DW-1:0] dat_q, out_q;
  logic [BW-1:0] ben_q;
  logic [LW-1:0] cnt_q, hl_q;
  logic          bad, acc_d, close;
  logic [LW-1:0] cnt_d;

  always_comb begin
    bad   = ph_q && (par_i != epf_even(64'({dat_q, ben_q})));
    close = ph_q && last_q;
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (ph_q) begin
      acc_d = close ? 1'b0 : (acc_q | bad);
      cnt_d = close ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      last_q <= 1'b0;
      dat_q  <= '0;
      ben_q  <= '0;
      acc_q  <= 1'b0;
      cnt_q  <= '0;
      dv_q   <= 1'b0;
      out_q  <= '0;
      derr_q <= 1'b0;
      hv_q   <= 1'b0;
      hp_q   <= 1'b0;
      hl_q   <= '0;
    end else begin
      ph_q  <= ph_i;
      dv_q  <= ph_q;
      hv_q  <= close;
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      if (ph_i) begin
        dat_q  <= dat_i;
        ben_q  <= ben_i;
        last_q <= last_i;
      end
      if (ph_q) begin
        out_q  <= dat_q;
        derr_q <= bad;
      end
      if (close) begin
        hp_q <= acc_q | bad;
        hl_q <= cnt_q + 1'b1;
      end
    end
  end

  assign dv_o   = dv_q;
  assign data_o = out_q;
  assign derr_o = derr_q;
  assign hv_o   = hv_q;
  assign hp_o   = hp_q;
  assign hl_o   = hl_q;

  a_r8_hdr_with_last_data: assert property (@(posedge clk) disable iff (!rst_n)
    hv_q |-> dv_q);
  a_r8_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    hv_q |-> (hl_q != '0));
  a_r9_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    hv_q |-> (!acc_q && cnt_q == '0));
  a_r7_error_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !last_q) |=> acc_q);
endmodule

// File: rtl/epf_top.sv
module epf_top #(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 4,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dn_valid,
  input  logic [DW-1:0] dn_data,
  input  logic [BW-1:0] dn_ben,
  input  logic          dn_last,
  input  logic          dn_poison,
  output logic          bus_phase_o,
  output logic [DW-1:0] bus_dat_o,
  output logic [BW-1:0] bus_ben_o,
  output logic          bus_par_en_o,
  output logic          bus_parity_o,
  input  logic          bus_phase_i,
  input  logic [DW-1:0] bus_dat_i,
  input  logic [BW-1:0] bus_ben_i,
  input  logic          bus_last_i,
  input  logic          bus_parity_i,
  output logic          up_dv_o,
  output logic [DW-1:0] up_data_o,
  output logic          up_derr_o,
  output logic          up_hdr_valid_o,
  output logic          up_hdr_poison_o,
  output logic [LW-1:0] up_hdr_len_o
);
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  epf_dn_gen #(.DW(DW), .BW(BW)) u_dn (
    .clk(clk), .rst_n(rst_s_n),
    .in_valid(dn_valid), .in_data(dn_data), .in_ben(dn_ben),
    .in_last(dn_last), .in_poison(dn_poison),
    .ph_o(bus_phase_o), .dat_o(bus_dat_o), .ben_o(bus_ben_o),
    .par_en_o(bus_par_en_o), .par_o(bus_parity_o)
  );

  epf_up_chk #(.DW(DW), .BW(BW), .LW(LW)) u_up (
    .clk(clk), .rst_n(rst_s_n),
    .ph_i(bus_phase_i), .dat_i(bus_dat_i), .ben_i(bus_ben_i),
    .last_i(bus_last_i), .par_i(bus_parity_i),
    .dv_o(up_dv_o), .data_o(up_data_o), .derr_o(up_derr_o),
    .hv_o(up_hdr_valid_o), .hp_o(up_hdr_poison_o), .hl_o(up_hdr_len_o)
  );
endmodule

// File: tb/sim_epf_top.sv
module sim_epf_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dn_valid, dn_last, dn_poison;
  logic [31:0] dn_data;
  logic [3:0]  dn_ben;
  logic        bus_phase_o, bus_par_en_o, bus_parity_o;
  logic [31:0] bus_dat_o;
  logic [3:0]  bus_ben_o;
  logic        bus_phase_i, bus_last_i, bus_parity_i;
  logic [31:0] bus_dat_i;
  logic [3:0]  bus_ben_i;
  logic        up_dv_o, up_derr_o, up_hdr_valid_o, up_hdr_poison_o;
  logic [31:0] up_data_o;
  logic [7:0]  up_hdr_len_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  epf_top u0 (.*);

  function automatic logic [31:0] pat(input int seed, input int i);
    return (32'(seed) * 32'h01030507) ^ (32'(i) * 32'h9E3779B1);
  endfunction
  function automatic logic [3:0] bpat(input int seed, input int i);
    return 4'(seed + 3 * i);
  endfunction
  function automatic logic evenbit(input logic [31:0] d, input logic [3:0] b);
    return logic'($countones({d, b}) % 2);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    dn_valid = 0; dn_last = 0; dn_poison = 0; dn_data = '0; dn_ben = '0;
    bus_phase_i = 0; bus_last_i = 0; bus_parity_i = 0; bus_dat_i = '0; bus_ben_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 bus_phase", 64'(bus_phase_o), 0);
    chk("R1 par_en", 64'(bus_par_en_o), 0);
    chk("R1 up_dv", 64'(up_dv_o), 0);
    chk("R1 hdr_valid", 64'(up_hdr_valid_o), 0);
  endtask

  // Downstream packet: n dwords, poison sampled on beat 0; if toggle,
  // dn_poison flips on odd later beats (must be ignored, R5).
  task automatic t_dn(input int n, input int seed, input logic pois, input bit toggle);
    for (int i = 0; i <= n + 1; i++) begin
      @(negedge clk);
      if (i >= 1 && i <= n) begin
        chk("R2 phase", 64'(bus_phase_o), 1);
        chk("R2 data", 64'(bus_dat_o), 64'(pat(seed, i - 1)));
        chk("R2 ben", 64'(bus_ben_o), 64'(bpat(seed, i - 1)));
      end
      if (i == n + 1) chk("R2 phase ends", 64'(bus_phase_o), 0);
      if (i >= 2) begin
        chk("R3 par_en", 64'(bus_par_en_o), 1);
        chk(pois ? "R4 inverted parity" : (toggle ? "R5 poison change ignored" : "R3 even parity"),
            64'(bus_parity_o),
            64'(evenbit(pat(seed, i - 2), bpat(seed, i - 2)) ^ pois));
      end
      if (i < n) begin
        dn_valid  = 1;
        dn_data   = pat(seed, i);
        dn_ben    = bpat(seed, i);
        dn_last   = (i == n - 1);
        dn_poison = (i == 0) ? pois : (toggle ? (pois ^ logic'(i % 2)) : pois);
      end else begin
        dn_valid = 0; dn_last = 0; dn_poison = 0;
      end
    end
  endtask

  // Upstream transaction: n phases, phase k gets bad parity if bad[k].
  task automatic t_up(input int n, input int seed, input logic [7:0] bad, input string tag);
    logic exp_p;
    exp_p = 1'b0;
    for (int k = 0; k < n; k++) exp_p |= bad[k];
    for (int i = 0; i <= n + 1; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R6 dv", 64'(up_dv_o), 1);
        chk("R6 data unchanged", 64'(up_data_o), 64'(pat(seed, i - 2)));
        chk("R6 derr", 64'(up_derr_o), 64'(bad[i - 2]));
      end
      chk("R8 header timing", 64'(up_hdr_valid_o), 64'(i == n + 1));
      if (i == n + 1) begin
        chk({tag, " poison"}, 64'(up_hdr_poison_o), 64'(exp_p));
        chk("R8 length", 64'(up_hdr_len_o), 64'(n));
      end
      if (i < n) begin
        bus_phase_i = 1;
        bus_dat_i   = pat(seed, i);
        bus_ben_i   = bpat(seed, i);
        bus_last_i  = (i == n - 1);
      end else begin
        bus_phase_i = 0; bus_last_i = 0;
      end
      if (i >= 1 && i <= n)
        bus_parity_i = evenbit(pat(seed, i - 1), bpat(seed, i - 1)) ^ bad[i - 1];
      else
        bus_parity_i = 0;
    end
    @(negedge clk);
    chk("R8 header one cycle", 64'(up_hdr_valid_o), 0);
  endtask

  initial begin
    t_reset();
    t_dn(4, 1, 1'b0, 0);
    t_dn(5, 2, 1'b1, 0);
    t_dn(3, 3, 1'b0, 0);
    t_dn(6, 4, 1'b1, 1);
    t_dn(6, 5, 1'b0, 1);
    t_dn(1, 6, 1'b1, 0);
    t_up(4, 7, 8'h00, "R7 clean");
    t_up(4, 8, 8'h01, "R7 first bad");
    t_up(5, 9, 8'h04, "R7 middle bad");
    t_up(3, 10, 8'h04, "R7 last bad");
    t_up(3, 11, 8'h00, "R9 clean after bad");
    t_up(1, 12, 8'h01, "R7 single bad");
    t_up(8, 13, 8'h00, "R9 long clean");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule